// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two two's-complement operands of `WIDTH` bits and returns the full signed product of `2*WIDTH` bits, split into an upper word and a lower word. It works one bit per clock. The multiplier operand sits in the lower half of a product register that shifts right. Each step looks at the lowest bit of that register together with the bit that was shifted out on the step before. A pair of 1 (current) and 0 (previous) subtracts the multiplicand from the upper half. A pair of 0 and 1 adds it. The pairs 0,0 and 1,1 leave the upper half unchanged. The register then shifts right arithmetically by one place. The previous-bit flop is cleared when an operation is loaded.

The add or subtract is done at `WIDTH+1` bits. This keeps the sign correct when the multiplicand is the most negative value. A user pulses `start` with both operands present while the block is not busy. `busy` stays high for exactly `WIDTH` cycles, and then `done` is high for one cycle while the product is valid. The product stays on the outputs until the next operation is accepted.

Control is a three-state machine:
- `ST_IDLE` moves to `ST_RUN` on `start` (transition *accept*).
- `ST_RUN` stays in `ST_RUN` until its iteration counter reaches `WIDTH-1`, then moves to `ST_FINISH` (*last step*).
- `ST_FINISH` moves to `ST_RUN` on `start` (*chain*), or otherwise back to `ST_IDLE` (*retire*).

Top module: `booth_mul`

## Requirements
- R1: While `rst_n` is low and after it is released, `busy` and `done` are 0 and `{prod_hi, prod_lo}` is 0 until an operation is accepted.
- R2: A `start` sampled high while `busy` is low and `done` is low captures `mcand` and `mplier`. `busy` is then 1 from the next cycle for exactly `WIDTH` consecutive cycles.
- R3: `done` is 1 for exactly one cycle, in the cycle right after the last `busy` cycle, and is never 1 together with `busy`.
- R4: In the `done` cycle, `{prod_hi, prod_lo}` equals the two's-complement product of the captured signed operands over `2*WIDTH` bits. `prod_hi` is the upper `WIDTH` bits. This holds for every operand pair, including those where either or both operands are -2^(WIDTH-1); for example, with `WIDTH`=4, 1110 × 0111 gives 1111 0010.
- R5: `start`, `mcand` and `mplier` are ignored while `busy` is 1. The running product, the `busy` length and the `done` timing are unchanged.
- R6: While `busy` is 0 and no operation is accepted, `{prod_hi, prod_lo}` keeps its last value, whatever the operand inputs do.
- R7: A `start` sampled in the `done` cycle is accepted like one from idle. The next operation then runs back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new multiplication |
| mcand | input | WIDTH | Signed multiplicand |
| mplier | input | WIDTH | Signed multiplier |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse; product valid |
| prod_hi | output | WIDTH | Upper half of signed product |
| prod_lo | output | WIDTH | Lower half of signed product |

## Verification
The bench builds the block with `WIDTH`=6. At that width every one of the 4096 signed operand pairs can be run, so all recoding patterns are covered. This includes runs of ones that reach the sign bit and both operands at -32. Most operations are chained from the `done` cycle. Directed sequences cover the 4-bit style case -2 × 7, `start` pulses and operand changes during a run, and long idle stretches in which the operand inputs toggle.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } step_op_t;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_pkg::*;
(
    input  logic     cur_bit,
    input  logic     prev_bit,
    output step_op_t op
);

    always_comb begin
        unique case ({cur_bit, prev_bit})
            2'b10:   op = OP_SUB;   // a run of ones begins
            2'b01:   op = OP_ADD;   // a run of ones has ended
            default: op = OP_NONE;  // inside a run of ones or of zeros
        endcase
    end

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
    import booth_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);

    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST_ITER = CW'(WIDTH - 1);

    seq_state_t state, state_nxt;
    logic [CW-1:0] iter;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // iteration counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    iter <= '0;
        else if (load) iter <= '0;
        else if (step) iter <= iter + 1'b1;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (start) state_nxt = ST_RUN;
            ST_RUN:    if (iter == LAST_ITER) state_nxt = ST_FINISH;
            ST_FINISH: state_nxt = start ? ST_RUN : ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state)
            ST_IDLE:   load = start;
            ST_RUN: begin
                busy = 1'b1;
                step = 1'b1;
            end
            ST_FINISH: begin
                done = 1'b1;
                load = start;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
    import booth_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [WIDTH-1:0] mcand_in,
    input  logic [WIDTH-1:0] mplier_in,
    output logic [WIDTH-1:0] hi_q,
    output logic [WIDTH-1:0] lo_q
);

    localparam int EW = WIDTH + 1;

    logic [WIDTH-1:0] mc_q;
    logic             prev_q;
    logic [EW-1:0]    hi_ext, mc_ext, sum;
    step_op_t         op;

    booth_recode u_recode (
        .cur_bit  (lo_q[0]),
        .prev_bit (prev_q),
        .op       (op)
    );

    assign hi_ext = {hi_q[WIDTH-1], hi_q};
    assign mc_ext = {mc_q[WIDTH-1], mc_q};

    always_comb begin
        unique case (op)
            OP_ADD:  sum = hi_ext + mc_ext;
            OP_SUB:  sum = hi_ext - mc_ext;
            default: sum = hi_ext;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q   <= '0;
            lo_q   <= '0;
            mc_q   <= '0;
            prev_q <= 1'b0;
        end else if (load) begin
            hi_q   <= '0;
            lo_q   <= mplier_in;
            mc_q   <= mcand_in;
            prev_q <= 1'b0;
        end else if (step) begin
            hi_q   <= sum[EW-1:1];
            lo_q   <= {sum[0], lo_q[WIDTH-1:1]};
            prev_q <= lo_q[0];
        end
    end

endmodule

// File: rtl/booth_mul.sv
module booth_mul #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] mcand,
    input  logic [WIDTH-1:0] mplier,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] prod_hi,
    output logic [WIDTH-1:0] prod_lo
);

    logic load, step;

    booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    booth_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .mcand_in  (mcand),
        .mplier_in (mplier),
        .hi_q      (prod_hi),
        .lo_q      (prod_lo)
    );

endmodule

// File: rtl/booth_mul_checks.sv
module booth_mul_checks #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] prod_hi,
    input logic [WIDTH-1:0] prod_lo
);

    localparam int LW = $clog2(WIDTH + 1) + 1;

    logic [LW-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (!busy && !done));

    a_r2_busy_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r2_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == LW'(WIDTH)));

    a_r3_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r6_product_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable({prod_hi, prod_lo}));

endmodule

bind booth_mul booth_mul_checks #(.WIDTH(WIDTH)) u_checks (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .prod_hi (prod_hi),
    .prod_lo (prod_lo)
);

// File: tb/booth_mul_test.sv
module booth_mul_test;

    localparam int W = 6;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [W-1:0] mcand = '0;
    logic [W-1:0] mplier = '0;
    logic busy, done;
    logic [W-1:0] prod_hi, prod_lo;

    int n_cmp = 0;
    int n_bad = 0;
    string phase = "R1";
    bit finished = 1'b0;

    // behavioural reference state
    bit m_valid = 1'b0;
    bit m_run = 1'b0;
    bit m_done = 1'b0;
    int m_left = 0;
    logic [2*W-1:0] m_prod = '0;
    logic [2*W-1:0] m_pend = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    booth_mul #(.WIDTH(W)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mcand   (mcand),
        .mplier  (mplier),
        .busy    (busy),
        .done    (done),
        .prod_hi (prod_hi),
        .prod_lo (prod_lo)
    );

    function automatic logic [2*W-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b);
        longint sa, sb, p;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        p = sa * sb;
        return p[2*W-1:0];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid = 1'b1;
            m_run = 1'b0;
            m_done = 1'b0;
            m_left = 0;
            m_prod = '0;
        end else if (m_valid) begin
            bit nd;
            nd = 1'b0;
            if (m_run) begin
                m_left--;
                if (m_left == 0) begin
                    m_run = 1'b0;
                    nd = 1'b1;
                    m_prod = m_pend;
                end
            end else if (start) begin
                m_run = 1'b1;
                m_left = W;
                m_pend = ref_mul(mcand, mplier);
            end
            m_done = nd;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (m_valid && !finished) begin
            n_cmp++;
            if (busy !== m_run) begin
                n_bad++;
                $display("FAIL [%s busy, R2 R5] busy=%b expected %b", phase, busy, m_run);
            end
            n_cmp++;
            if (done !== m_done) begin
                n_bad++;
                $display("FAIL [%s done, R3] done=%b expected %b", phase, done, m_done);
            end
            if (!m_run) begin
                n_cmp++;
                if ({prod_hi, prod_lo} !== m_prod) begin
                    n_bad++;
                    $display("FAIL [%s product, %s] got %h expected %h", phase,
                             m_done ? "R4" : "R6", {prod_hi, prod_lo}, m_prod);
                end
            end
        end
    end

    // drive start for one cycle; returns at the negedge where done is high
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b);
        start = 1'b1;
        mcand = a;
        mplier = b;
        @(negedge clk);
        start = 1'b0;
        repeat (W) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL [watchdog] run did not finish, got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        phase = "R1";
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R4: directed cases, then every pair
        phase = "R4";
        run_op(6'b111110, 6'b000111);         // -2 x 7
        @(negedge clk);
        run_op(6'b100000, 6'b100000);         // most negative squared
        @(negedge clk);
        run_op(6'b100000, 6'b011111);
        @(negedge clk);
        run_op(6'b011111, 6'b100000);
        @(negedge clk);
        for (int a = -32; a < 32; a++) begin
            for (int b = -32; b < 32; b++) begin
                run_op(W'(a), W'(b));          // also chains from done: R7
            end
        end
        @(negedge clk);

        // R5: start and operand changes while busy
        phase = "R5";
        start = 1'b1; mcand = 6'd13; mplier = 6'b110011;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < W - 1; k++) begin
            start = k[0];
            mcand = W'(k * 7);
            mplier = W'(k * 11 + 3);
            @(negedge clk);
        end
        start = 1'b0;
        repeat (3) @(negedge clk);

        // R6: idle with moving operand inputs
        phase = "R6";
        for (int k = 0; k < 20; k++) begin
            mcand = W'(k * 5);
            mplier = W'(~k);
            @(negedge clk);
        end

        // R7: back-to-back chain from the done cycle
        phase = "R7";
        run_op(6'd31, 6'd31);
        run_op(6'b100001, 6'd2);
        run_op(6'd0, 6'b100000);
        @(negedge clk);
        repeat (3) @(negedge clk);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule